// File: doc/BRIEF.md
# Card Host Status Word with Latched and Live Flags

This block builds the 32-bit status word of a memory-card host controller. Thirteen positions hold latched event flags. The command and data engines raise these with single-cycle pulses, and each flag stays set until software writes a 1 to its position in a write-only clear register. Eleven other positions are live flags. They show the current level of the FIFO and activity signals, and they update every cycle. The top eight bits are reserved and always read as zero.

A mask register selects which status bits can raise the controller's interrupt. The interrupt output is the OR of the masked status bits, delayed by one register stage. Software reads the status word and the mask through a plain address-decoded read port. It writes the clear register and the mask through a plain write port. No data stream crosses this block, so there is no valid/ready handshake. Every pin is a level or a single-cycle pulse.

Top module: `sdsts_status_reg`

## Requirements
- R1: After reset, the status word (offset 0x34) reads zero, the mask (offset 0x3C) reads zero, and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets the matching latched flag on the next clock edge. Event inputs 0 to 10 map to status bits 0 to 10. Input 11 (card interrupt) maps to bit 22. Input 12 (ATA-command completion) maps to bit 23. Bit 0 is the command CRC error and bit 10 is block done with good CRC.
- R3: A latched flag stays set until a write to the clear register (offset 0x38) carries a 1 at that flag's status bit position. The flag then reads zero from the next cycle onward.
- R4: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R5: Status bits 21 to 11 equal `live_i[10:0]` in the same cycle, with no latching. Bit 11 is command in progress and bit 21 is receive data available.
- R6: Status bits 31 to 24 always read zero.
- R7: A write to the status offset changes nothing. Clear-register bits at live or reserved positions (31:24, 21:11) have no effect.
- R8: A write to offset 0x3C stores all 32 bits of the mask, and the mask reads back at that offset. Each cycle, `irq_o` equals the OR over (status AND mask) as it stood in the previous cycle.
- R9: A read at any offset other than 0x34 or 0x3C returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| evt_i | input | 13 | Single-cycle event pulses from the engines |
| live_i | input | 11 | FIFO and activity levels |
| irq_o | output | 1 | Registered masked interrupt |

## Verification
On every cycle, the assertions check four things:
- an event pulse always leaves its flag set, even when a clear arrives in the same cycle;
- a flag never drops unless it was cleared;
- a clear without a competing set always empties the flag;
- a write to the status offset leaves the latched flags as they were.

The assertions also check that a mask write lands and that the interrupt follows the masked status one cycle later. Only the bench scenarios show the exact bit mapping of events and live levels into the word, the reserved and foreign-offset zeros, and the reset values as seen through the read port.

// File: rtl/sdsts_pkg.sv
package sdsts_pkg;
  localparam int WORD_W   = 32;
  localparam int N_EVT    = 13;
  localparam int N_LIVE   = 11;
  localparam int LIVE_LSB = 11;
  localparam int LOW_EVT  = 11;  // events kept at their own index
  localparam int HIGH_GAP = N_LIVE;

  // status bit position of latched event k
  function automatic int evt_pos(input int k);
    return (k < LOW_EVT) ? k : k + HIGH_GAP;
  endfunction
endpackage

// File: rtl/sdsts_sticky.sv
module sdsts_sticky #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[k] <= 1'b0;
      else if (set_i[k])   flag_q[k] <= 1'b1;
      else if (clr_i[k])   flag_q[k] <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i))); // R4
  AST_NO_SPURIOUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_q) & ~$past(clr_i)) & ~flag_q) == '0)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(clr_i & ~set_i)) == '0)); // R3
endmodule

// File: rtl/sdsts_pack.sv
module sdsts_pack
  import sdsts_pkg::*;
(
  input  logic [N_EVT-1:0]  flag_i,
  input  logic [N_LIVE-1:0] live_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] evt_part;
  logic [WORD_W-1:0] live_part;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam bit IS_LIVE = (b >= LIVE_LSB) && (b < LIVE_LSB + N_LIVE);
    localparam int EVT_IDX = (b < LOW_EVT) ? b : b - HIGH_GAP;
    localparam bit IS_EVT  = !IS_LIVE && (EVT_IDX >= 0) && (EVT_IDX < N_EVT);
    if (IS_LIVE) begin : g_live
      assign live_part[b] = live_i[b-LIVE_LSB];
      assign evt_part[b]  = 1'b0;
    end else if (IS_EVT) begin : g_evt
      assign live_part[b] = 1'b0;
      assign evt_part[b]  = flag_i[EVT_IDX];
    end else begin : g_rsvd
      assign live_part[b] = 1'b0;
      assign evt_part[b]  = 1'b0;
    end
  end

  assign word_o = evt_part | live_part;
endmodule

// File: rtl/sdsts_irq.sv
module sdsts_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_i & mask_q);
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  AST_MASK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata))); // R8
endmodule

// File: rtl/sdsts_status_reg.sv
module sdsts_status_reg
  import sdsts_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  STA_OFS = 8'h34,
  parameter logic [7:0]  CLR_OFS = 8'h38,
  parameter logic [7:0]  MSK_OFS = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [N_LIVE-1:0] live_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(STA_OFS);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_OFS);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(MSK_OFS);

  logic              clr_hit, msk_hit;
  logic [N_EVT-1:0]  clr_vec;
  logic [N_EVT-1:0]  flags;
  logic [WORD_W-1:0] status_w;
  logic [WORD_W-1:0] mask_w;

  assign clr_hit = wr_en && (wr_addr == A_CLR);
  assign msk_hit = wr_en && (wr_addr == A_MSK);

  for (genvar k = 0; k < N_EVT; k++) begin : g_clr
    assign clr_vec[k] = clr_hit & wr_data[evt_pos(k)];
  end

  sdsts_sticky #(.N(N_EVT)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_vec), .flag_o(flags)
  );

  sdsts_pack u_pack (
    .flag_i(flags), .live_i(live_i), .word_o(status_w)
  );

  sdsts_irq #(.W(WORD_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_we(msk_hit), .mask_wdata(wr_data),
    .status_i(status_w), .mask_o(mask_w), .irq_o(irq_o)
  );

  always_comb begin
    if (rd_addr == A_STA)      rd_data = status_w;
    else if (rd_addr == A_MSK) rd_data = mask_w;
    else                       rd_data = '0;
  end

  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STA && evt_i == '0) |=> $stable(flags)); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(status_w) & $past(mask_w)))); // R8
endmodule

// File: tb/test_sdsts_status_reg.sv
module test_sdsts_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rd_addr = 8'h34;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h0;
  logic [31:0] wr_data = 32'h0;
  logic [12:0] evt_i = '0;
  logic [10:0] live_i = '0;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_sticky = 0;
  logic [31:0] m_mask = 0;
  logic        m_irq = 0;

  always #10 clk = ~clk;

  sdsts_status_reg i_sdsts_status_reg (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_i(evt_i), .live_i(live_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] ev2word(input logic [12:0] e);
    logic [31:0] w = 0;
    for (int k = 0; k < 13; k++) if (e[k]) w[(k < 11) ? k : k + 11] = 1'b1;
    return w;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [12:0] e, input logic [10:0] l, input logic we,
                      input logic [7:0] wa, input logic [31:0] wd, input logic [7:0] ra,
                      input string tag);
    logic [31:0] cur, exp_rd, clr;
    @(negedge clk);
    evt_i = e; live_i = l; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    #2;
    cur = m_sticky | (32'(l) << 11);
    exp_rd = (ra == 8'h34) ? cur : (ra == 8'h3C) ? m_mask : 32'h0;
    check(tag, "rd_data", rd_data, exp_rd);
    check(tag, "irq_o", {31'h0, irq_o}, {31'h0, m_irq});
    @(posedge clk);
    clr = (we && wa == 8'h38) ? (wd & 32'h00C0_07FF) : 32'h0;
    m_irq = |(cur & m_mask);
    m_sticky = (m_sticky & ~clr) | ev2word(e);
    if (we && wa == 8'h3C) m_mask = wd;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R1", "status in reset", rd_data, 32'h0);
    check("R1", "irq in reset", {31'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 8'h3C, "R1");
    step(0, 0, 0, 0, 0, 8'h34, "R1");
    // R2 each event alone
    for (int k = 0; k < 13; k++) step(13'(1) << k, 0, 0, 0, 0, 8'h34, "R2");
    step(0, 0, 0, 0, 0, 8'h34, "R2");
    // R6 all flags and live set
    step(0, 11'h7FF, 0, 0, 0, 8'h34, "R6");
    // R7 writes to status ignored; live/reserved clear bits no effect
    step(0, 11'h2A5, 1, 8'h34, 32'h0, 8'h34, "R7");
    step(0, 11'h2A5, 1, 8'h38, 32'hFF3F_F800, 8'h34, "R7");
    step(0, 11'h15A, 0, 0, 0, 8'h34, "R7");
    // R3 clear some flags
    step(0, 0, 1, 8'h38, 32'h0080_0401, 8'h34, "R3");
    step(0, 0, 0, 0, 0, 8'h34, "R3");
    step(0, 0, 1, 8'h38, 32'h0040_03FE, 8'h34, "R3");
    step(0, 0, 0, 0, 0, 8'h34, "R3");
    // R4 set and clear same cycle
    step(13'h1005, 0, 1, 8'h38, 32'h00C0_07FF, 8'h34, "R4");
    step(0, 0, 0, 0, 0, 8'h34, "R4");
    // R5 live patterns
    step(0, 11'h001, 0, 0, 0, 8'h34, "R5");
    step(0, 11'h400, 0, 0, 0, 8'h34, "R5");
    step(0, 11'h3C3, 0, 0, 0, 8'h34, "R5");
    // R9 other offsets
    step(0, 11'h7FF, 0, 0, 0, 8'h38, "R9");
    step(0, 11'h7FF, 0, 0, 0, 8'h00, "R9");
    // R8 mask and irq
    step(0, 0, 1, 8'h3C, 32'h0000_0800, 8'h3C, "R8");
    step(0, 0, 0, 0, 0, 8'h3C, "R8");
    step(0, 11'h001, 0, 0, 0, 8'h34, "R8");
    step(0, 0, 0, 0, 0, 8'h34, "R8");
    step(0, 0, 0, 0, 0, 8'h34, "R8");
    step(0, 0, 1, 8'h3C, 32'h0040_0000, 8'h3C, "R8");
    step(13'h0800, 0, 0, 0, 0, 8'h34, "R8");
    step(0, 0, 0, 0, 0, 8'h34, "R8");
    step(0, 0, 1, 8'h38, 32'h0040_0000, 8'h34, "R8");
    step(0, 0, 0, 0, 0, 8'h34, "R8");
    step(0, 0, 0, 0, 0, 8'h34, "R8");
    step(13'h0004, 0, 1, 8'h3C, 32'hFFFF_FFFF, 8'h3C, "R8");
    step(0, 0, 0, 0, 0, 8'h34, "R8");
    step(0, 0, 0, 0, 0, 8'h34, "R8");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule